// File: doc/BRIEF.md
# Auto-Indexing I2C Byte Buffer Port

This block puts a 538-entry byte store behind a single host-visible data word and gives an I2C sequencer a second, directly addressed path into the same store. The host never supplies an address with each byte. It first writes the data word with the load flag set, which places a start position into an internal pointer and fixes the host read direction. After that, each plain write deposits one byte at the pointer and each read fetches one byte from it. Both operations move the pointer on by one. Because the depth is not a power of two, the pointer returns to 0 explicitly when it leaves the top entry.

There is one physical memory port, and the sequencer owns it whenever it asks. A host access that needs the memory in the same cycle sees `host_ready` low and must hold its request. An index load never touches the memory, so it is always accepted. Reads from either side come back one cycle after the access that was accepted.

The response tracker is a four-state machine. RS_QUIET means no read is outstanding. RS_HOST_READ means a host fetch from memory returns this cycle. RS_HOST_BLANK means a host read issued while the direction is write returns zero this cycle. RS_SEQ_READ means a sequencer read returns this cycle. On every clock the next state is chosen from the access accepted in that cycle: a sequencer read goes to RS_SEQ_READ, a host fetch to RS_HOST_READ, a host read while writing to RS_HOST_BLANK, and anything else to RS_QUIET.

Top module: `i2c_bytebuf_port`

## Requirements
- R1: After reset the pointer is 0 and the host direction is write, so no read response is pending and `host_ready` is high.
- R2: The host word is 20 bits wide. Bits [7:0] hold the data byte, bits [17:8] the index, bit 18 the direction (1 = read) and bit 19 the load flag. A host write with bit 19 set loads the index into the pointer and bit 18 into the direction. An index of 538 or more loads 0.
- R3: A host write with bit 19 clear stores bits [7:0] at the pointer and then advances the pointer by one.
- R4: When the direction is read, an accepted host read returns the byte at the pointer on `host_rdata` with `host_rvalid` one cycle later, and the pointer advances.
- R5: The pointer advances from 537 to 0.
- R6: When the direction is write, an accepted host read returns 0 with `host_rvalid` one cycle later and leaves the pointer unchanged.
- R7: When the sequencer is active in a cycle, any host access other than an index load is held (`host_ready` low) and takes effect after the sequencer access. An index load is accepted in the same cycle.
- R8: A sequencer write stores `seq_wdata` at `seq_addr`. A sequencer read returns the byte at `seq_addr` on `seq_rdata` with `seq_rvalid` one cycle later.
- R9: An index load leaves the buffer contents unchanged.
- R10: Bit 18 of a host write with bit 19 clear has no effect on the direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host access request, held until accepted |
| host_write | input | 1 | 1 = write data word, 0 = read |
| host_wdata | input | 20 | Host data word (load flag, direction, index, byte) |
| host_ready | output | 1 | Host access accepted this cycle |
| host_rvalid | output | 1 | Host read response valid |
| host_rdata | output | 8 | Host read byte |
| seq_valid | input | 1 | Sequencer access request |
| seq_write | input | 1 | 1 = sequencer write, 0 = read |
| seq_addr | input | 10 | Sequencer buffer address |
| seq_wdata | input | 8 | Sequencer write byte |
| seq_rvalid | output | 1 | Sequencer read response valid |
| seq_rdata | output | 8 | Sequencer read byte |

## Verification
The bench fills the two top entries and then keeps writing. A pointer that runs into entry 538, or that wraps one entry late, shows up as a wrong byte when the host reads the span back from 536. It starts a host read on the same cycle as a sequencer write to the same entry. A design that let the host through first would return the stale byte instead of the sequencer's. It checks that a read issued while the direction is write returns zero and does not move the pointer, so the next store lands where a design that advanced anyway would not put it. It also checks that an index load that carries a data byte does not corrupt the buffer, and that an out-of-range index loads 0.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;

    // Host operation chosen in a cycle
    typedef enum logic [2:0] {
        HOP_IDLE,
        HOP_LOAD,
        HOP_STORE,
        HOP_FETCH,
        HOP_BLANK
    } host_op_e;

    // Which read response is returned in the current cycle
    typedef enum logic [1:0] {
        RS_QUIET,
        RS_HOST_READ,
        RS_HOST_BLANK,
        RS_SEQ_READ
    } rsp_state_e;

endpackage

// File: rtl/i2cb_mem.sv
module i2cb_mem #(
    parameter int DEPTH = 538,
    parameter int AW    = 10,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we && addr <= TOP) begin
            cells[addr] <= wdata;
        end
        if (re) begin
            rdata <= (addr <= TOP) ? cells[addr] : '0;
        end
    end
endmodule

// File: rtl/i2cb_ptr.sv
module i2cb_ptr
    import i2cb_pkg::*;
#(
    parameter int DEPTH = 538,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  host_op_e      hop,
    input  logic [AW-1:0] load_idx,
    input  logic          load_dir,
    output logic [AW-1:0] ptr,
    output logic          dir_rd
);
    localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

    logic          advance;
    logic [AW-1:0] ptr_next;

    always_comb begin
        advance  = (hop == HOP_STORE) || (hop == HOP_FETCH);
        ptr_next = (ptr == TOP) ? '0 : ptr + AW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr    <= '0;
            dir_rd <= 1'b0;
        end else if (hop == HOP_LOAD) begin
            ptr    <= (load_idx <= TOP) ? load_idx : '0;
            dir_rd <= load_dir;
        end else if (advance) begin
            ptr    <= ptr_next;
        end
    end

    // R5
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && ptr == TOP) |=> (ptr == '0));

    // R2
    idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hop == HOP_LOAD && load_idx <= TOP) |=> (ptr == $past(load_idx)));

    // R6
    blank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hop == HOP_BLANK || hop == HOP_IDLE) |=> $stable(ptr));
endmodule

// File: rtl/i2cb_arb.sv
module i2cb_arb
    import i2cb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     host_valid,
    input  logic     host_write,
    input  logic     host_load,
    input  logic     dir_rd,
    input  logic     seq_valid,
    input  logic     seq_write,
    output host_op_e hop,
    output logic     seq_rd_go,
    output logic     seq_wr_go,
    output logic     host_ready,
    output logic     host_rvalid,
    output logic     host_from_mem,
    output logic     seq_rvalid
);
    rsp_state_e state_q, state_d;

    // Grant: sequencer first, an index load never needs the memory
    always_comb begin
        seq_rd_go  = seq_valid && !seq_write;
        seq_wr_go  = seq_valid && seq_write;
        host_ready = !(seq_valid && host_valid && !(host_write && host_load));
        hop        = HOP_IDLE;
        if (host_valid && host_ready) begin
            if (host_write) begin
                hop = host_load ? HOP_LOAD : HOP_STORE;
            end else begin
                hop = dir_rd ? HOP_FETCH : HOP_BLANK;
            end
        end
    end

    // Next response state
    always_comb begin
        if (seq_rd_go) begin
            state_d = RS_SEQ_READ;
        end else if (hop == HOP_FETCH) begin
            state_d = RS_HOST_READ;
        end else if (hop == HOP_BLANK) begin
            state_d = RS_HOST_BLANK;
        end else begin
            state_d = RS_QUIET;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RS_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        host_rvalid   = 1'b0;
        host_from_mem = 1'b0;
        seq_rvalid    = 1'b0;
        unique case (state_q)
            RS_QUIET:      ;
            RS_HOST_READ:  begin host_rvalid = 1'b1; host_from_mem = 1'b1; end
            RS_HOST_BLANK: host_rvalid = 1'b1;
            RS_SEQ_READ:   seq_rvalid = 1'b1;
            default:       ;
        endcase
    end

    // R8
    seq_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_valid && !seq_write) |=> (seq_rvalid && !host_rvalid));

    // R4
    fetch_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hop == HOP_FETCH) |=> (host_rvalid && host_from_mem));

    // R6
    blank_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hop == HOP_BLANK) |=> (host_rvalid && !host_from_mem));
endmodule

// File: rtl/i2c_bytebuf_port.sv
module i2c_bytebuf_port
    import i2cb_pkg::*;
#(
    parameter  int DEPTH = 538,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int HW_W  = IDX_W + 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_valid,
    input  logic             host_write,
    input  logic [HW_W-1:0]  host_wdata,
    output logic             host_ready,
    output logic             host_rvalid,
    output logic [7:0]       host_rdata,
    input  logic             seq_valid,
    input  logic             seq_write,
    input  logic [IDX_W-1:0] seq_addr,
    input  logic [7:0]       seq_wdata,
    output logic             seq_rvalid,
    output logic [7:0]       seq_rdata
);
    localparam int BIT_DIR  = IDX_W + 8;
    localparam int BIT_LOAD = IDX_W + 9;

    logic             f_load, f_dir;
    logic [IDX_W-1:0] f_idx;
    logic [7:0]       f_byte;
    host_op_e         hop;
    logic             seq_rd_go, seq_wr_go, host_from_mem, dir_rd;
    logic [IDX_W-1:0] ptr, mem_addr;
    logic             mem_we, mem_re;
    logic [7:0]       mem_wdata, mem_q;

    always_comb begin
        f_byte = host_wdata[7:0];
        f_idx  = host_wdata[IDX_W+7:8];
        f_dir  = host_wdata[BIT_DIR];
        f_load = host_wdata[BIT_LOAD];
    end

    i2cb_arb u_arb (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_valid    (host_valid),
        .host_write    (host_write),
        .host_load     (f_load),
        .dir_rd        (dir_rd),
        .seq_valid     (seq_valid),
        .seq_write     (seq_write),
        .hop           (hop),
        .seq_rd_go     (seq_rd_go),
        .seq_wr_go     (seq_wr_go),
        .host_ready    (host_ready),
        .host_rvalid   (host_rvalid),
        .host_from_mem (host_from_mem),
        .seq_rvalid    (seq_rvalid)
    );

    i2cb_ptr #(.DEPTH(DEPTH), .AW(IDX_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .hop      (hop),
        .load_idx (f_idx),
        .load_dir (f_dir),
        .ptr      (ptr),
        .dir_rd   (dir_rd)
    );

    always_comb begin
        mem_we    = seq_wr_go || (hop == HOP_STORE);
        mem_re    = seq_rd_go || (hop == HOP_FETCH);
        mem_addr  = seq_valid ? seq_addr : ptr;
        mem_wdata = seq_valid ? seq_wdata : f_byte;
    end

    i2cb_mem #(.DEPTH(DEPTH), .AW(IDX_W), .DW(8)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .re    (mem_re),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (mem_q)
    );

    always_comb begin
        host_rdata = (host_rvalid && host_from_mem) ? mem_q : 8'h00;
        seq_rdata  = seq_rvalid ? mem_q : 8'h00;
    end

    // R7
    seq_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_valid && host_valid && !host_write) |=> !host_rvalid);
endmodule

// File: tb/i2c_bytebuf_port_bench.sv
module i2c_bytebuf_port_bench;
    localparam int DEPTH = 538;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_valid = 1'b0, host_write = 1'b0;
    logic [19:0] host_wdata = '0;
    logic        host_ready, host_rvalid;
    logic [7:0]  host_rdata;
    logic        seq_valid = 1'b0, seq_write = 1'b0;
    logic [9:0]  seq_addr = '0;
    logic [7:0]  seq_wdata = '0;
    logic        seq_rvalid;
    logic [7:0]  seq_rdata;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    i2c_bytebuf_port u_i2c_bytebuf_port (
        .clk(clk), .rst_n(rst_n),
        .host_valid(host_valid), .host_write(host_write), .host_wdata(host_wdata),
        .host_ready(host_ready), .host_rvalid(host_rvalid), .host_rdata(host_rdata),
        .seq_valid(seq_valid), .seq_write(seq_write), .seq_addr(seq_addr),
        .seq_wdata(seq_wdata), .seq_rvalid(seq_rvalid), .seq_rdata(seq_rdata)
    );

    // Reference model built from the requirements
    logic [7:0] bm [DEPTH];
    int         bptr = 0;
    bit         bdir = 0;
    logic [7:0] hq[$];
    string      hq_tag[$];
    logic [7:0] sq[$];
    string      sq_tag[$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [19:0] mkw(bit ld, bit dr, int idx, logic [7:0] b);
        return {ld, dr, 10'(idx), b};
    endfunction

    task automatic model_host(input bit wr, input logic [19:0] w, input string tag);
        if (wr && w[19]) begin
            bptr = (int'(w[17:8]) < DEPTH) ? int'(w[17:8]) : 0;
            bdir = w[18];
        end else if (wr) begin
            bm[bptr] = w[7:0];
            bptr = (bptr == DEPTH - 1) ? 0 : bptr + 1;
        end else if (bdir) begin
            hq.push_back(bm[bptr]); hq_tag.push_back(tag);
            bptr = (bptr == DEPTH - 1) ? 0 : bptr + 1;
        end else begin
            hq.push_back(8'h00); hq_tag.push_back(tag);
        end
    endtask

    task automatic model_seq(input bit wr, input int a, input logic [7:0] d, input string tag);
        if (wr) bm[a] = d;
        else begin sq.push_back(bm[a]); sq_tag.push_back(tag); end
    endtask

    task automatic host_issue(input bit wr, input logic [19:0] w, input string tag);
        @(negedge clk);
        host_valid = 1'b1; host_write = wr; host_wdata = w;
        #1;
        while (!host_ready) begin @(negedge clk); #1; end
        model_host(wr, w, tag);
        @(posedge clk); #1;
        host_valid = 1'b0;
    endtask

    task automatic seq_issue(input bit wr, input int a, input logic [7:0] d, input string tag);
        @(negedge clk);
        seq_valid = 1'b1; seq_write = wr; seq_addr = 10'(a); seq_wdata = d;
        model_seq(wr, a, d, tag);
        @(posedge clk); #1;
        seq_valid = 1'b0;
    endtask

    // Both ports request in the same cycle; host must wait one cycle
    task automatic contend(input bit hwr, input logic [19:0] hw, input bit swr,
                           input int a, input logic [7:0] d, input string tag);
        @(negedge clk);
        host_valid = 1'b1; host_write = hwr; host_wdata = hw;
        seq_valid = 1'b1; seq_write = swr; seq_addr = 10'(a); seq_wdata = d;
        #1;
        chk(host_ready == 1'b0, {tag, " host held"}, host_ready, 0);
        model_seq(swr, a, d, tag);
        @(posedge clk); #1;
        seq_valid = 1'b0;
        #1;
        chk(host_ready == 1'b1, {tag, " host released"}, host_ready, 1);
        model_host(hwr, hw, tag);
        @(posedge clk); #1;
        host_valid = 1'b0;
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (host_rvalid) begin
                if (hq.size() == 0) chk(1'b0, "R4 unexpected host response", host_rdata, 0);
                else begin
                    automatic logic [7:0] e = hq.pop_front();
                    automatic string t = hq_tag.pop_front();
                    chk(host_rdata === e, t, host_rdata, e);
                end
            end
            if (seq_rvalid) begin
                if (sq.size() == 0) chk(1'b0, "R8 unexpected seq response", seq_rdata, 0);
                else begin
                    automatic logic [7:0] e = sq.pop_front();
                    automatic string t = sq_tag.pop_front();
                    chk(seq_rdata === e, t, seq_rdata, e);
                end
            end
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) bm[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(host_rvalid == 1'b0 && seq_rvalid == 1'b0, "R1 no response after reset", host_rvalid, 0);
        chk(host_ready == 1'b1, "R1 ready after reset", host_ready, 1);
        host_issue(0, '0, "R1 read in reset direction is zero");
        host_issue(1, mkw(0, 0, 0, 8'hA5), "R1");
        seq_issue(0, 0, 0, "R1 first store at index 0");

        // R2 R3 R4: load, store a run, read it back
        host_issue(1, mkw(1, 0, 10, 8'h00), "R2");
        for (int i = 0; i < 5; i++) host_issue(1, mkw(0, 0, 0, 8'(8'h40 + i)), "R3");
        seq_issue(0, 12, 0, "R3 store lands at pointer");
        host_issue(1, mkw(1, 1, 10, 8'h00), "R2");
        for (int i = 0; i < 5; i++) host_issue(0, '0, "R4 auto-increment read");

        // R5 wrap
        host_issue(1, mkw(1, 0, 536, 8'h00), "R5");
        host_issue(1, mkw(0, 0, 0, 8'hD0), "R5");
        host_issue(1, mkw(0, 0, 0, 8'hD1), "R5");
        host_issue(1, mkw(0, 0, 0, 8'hD2), "R5");
        seq_issue(0, 0, 0, "R5 wrapped store at index 0");
        host_issue(1, mkw(1, 1, 536, 8'h00), "R5");
        for (int i = 0; i < 3; i++) host_issue(0, '0, "R5 wrapped read");

        // R6 read in write direction
        host_issue(1, mkw(1, 0, 20, 8'h00), "R6");
        host_issue(0, '0, "R6 read in write direction is zero");
        host_issue(1, mkw(0, 0, 0, 8'h77), "R6");
        seq_issue(0, 20, 0, "R6 pointer unchanged by blank read");

        // R2 out-of-range index loads 0
        host_issue(1, mkw(1, 0, 600, 8'h00), "R2");
        host_issue(1, mkw(0, 0, 0, 8'h3C), "R2");
        seq_issue(0, 0, 0, "R2 out-of-range index gives 0");

        // R9 load does not touch contents
        seq_issue(1, 5, 8'h11, "R9");
        host_issue(1, mkw(1, 0, 5, 8'hEE), "R9");
        seq_issue(0, 5, 0, "R9 load leaves buffer intact");

        // R10 direction bit on a plain store ignored
        host_issue(1, mkw(1, 0, 30, 8'h00), "R10");
        host_issue(1, mkw(0, 1, 0, 8'h99), "R10");
        host_issue(0, '0, "R10 direction unchanged by store");

        // R7 sequencer priority
        host_issue(1, mkw(1, 1, 40, 8'h00), "R7");
        contend(0, '0, 1, 40, 8'h55, "R7 host read after seq write");
        host_issue(1, mkw(1, 0, 50, 8'h00), "R7");
        seq_issue(1, 50, 8'h12, "R8");
        contend(1, mkw(0, 0, 0, 8'h34), 0, 50, 0, "R7 seq reads before host store");
        seq_issue(0, 50, 0, "R8 host store after seq read");
        // R7 index load accepted alongside sequencer
        @(negedge clk);
        host_valid = 1'b1; host_write = 1'b1; host_wdata = mkw(1, 1, 60, 8'h00);
        seq_valid = 1'b1; seq_write = 1'b1; seq_addr = 10'd60; seq_wdata = 8'h6A;
        #1;
        chk(host_ready == 1'b1, "R7 load accepted with sequencer", host_ready, 1);
        model_seq(1, 60, 8'h6A, "R8");
        model_host(1, mkw(1, 1, 60, 8'h00), "R7");
        @(posedge clk); #1;
        host_valid = 1'b0; seq_valid = 1'b0;
        host_issue(0, '0, "R7 R8 read after concurrent load");

        repeat (4) @(negedge clk);
        chk(hq.size() == 0, "R4 all host responses seen", hq.size(), 0);
        chk(sq.size() == 0, "R8 all seq responses seen", sq.size(), 0);
        summary();
        $finish;
    end
endmodule